// File: doc/BRIEF.md
# RTC-Well Power Status and Resume Selector

This block sits in the always-powered real-time-clock domain and keeps three status and policy bits that must survive the loss of main power. Two of the bits are sticky hardware flags. One records that the coin-cell battery was found weak or absent. The other records that the trickle supply dropped out. The third bit is a software-owned policy. It tells the platform whether to boot straight away when mains power comes back after a total loss, or to stay in a soft-off state. Each bit has its own clear rule and answers to a different set of resets.

Software reads and writes the bits through a plain 8-bit register port. When the power-good input rises, the block combines the policy bit with the sleep state that was in force before the loss and presents the state the platform should resume into. A thermal-trip shutdown forces the policy to soft-off in hardware. The resume-well reset is an asynchronous input. The block synchronises it onto the RTC clock, and while it is asserted the core domain is treated as unpowered, so software writes are dropped.

Top module: `rtc_pwr_status`

## Requirements
- R1: The status register is 8 bits wide. Bit 2 holds the battery flag, bit 1 the supply-failure flag and bit 0 the resume policy. Bits 7:3 always read 0, and `rd_data_o` reflects the stored bits combinationally.
- R2: The battery flag is set on the clock edge that sees `batt_weak_i` high. `rst_ni` does not clear it. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R3: The supply-failure flag is set on the clock edge that sees `trickle_fail_i` high. A write with bit 1 = 1 clears it, a write with bit 1 = 0 leaves it unchanged, and `rst_ni` clears it.
- R4: A write loads the policy bit from bit 0. `rst_ni` or a `rstctl_wr_i` pulse clears it. A `therm_trip_i` pulse sets it to 1.
- R5: When a hardware set event meets a software write or a reset-control clear of the same bit in the same cycle, the bit ends at 1.
- R6: On the first clock edge at which `pwr_good_i` is high after being low, `res_state_o` loads one of three values. It loads 0 (S0) when the policy is 0. It loads 4 (S4) when the policy is 1 and `slp_state_i` is 4. It loads 5 (S5) when the policy is 1 and `slp_state_i` is any other value. At all other times `res_state_o` holds its value, and it resets to 0.
- R7: `rsm_rst_ni` passes through a two-flop synchroniser on `clk_i`. While the synchronised value is low, writes are ignored. The resume-well reset clears none of the three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC clock |
| rst_ni | input | 1 | RTC-well reset, asynchronous, active low |
| rsm_rst_ni | input | 1 | Resume-well reset, asynchronous, active low |
| batt_weak_i | input | 1 | Weak or missing battery indication |
| trickle_fail_i | input | 1 | Trickle supply failure indication |
| therm_trip_i | input | 1 | Thermal-trip shutdown event |
| rstctl_wr_i | input | 1 | Reset-control port write strobe |
| slp_state_i | input | 3 | Sleep state before power loss (0 = S0, 4 = S4, 5 = S5) |
| pwr_good_i | input | 1 | Main power good |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| res_state_o | output | 3 | Selected resume state |

## Verification
A corrupted flag bit is visible on `rd_data_o` in the very next cycle, because the read path has no pipeline. Wrong clear or set precedence therefore shows up one edge after the offending stimulus. A fault in the resume selection reaches the ports only at the next rising edge of power-good, and it then persists on `res_state_o` until power-good rises again. A synchroniser of the wrong depth shows as writes accepted or dropped one cycle off from the edges at which the resume reset changes.

// File: rtl/rtc_pwr_pkg.sv
package rtc_pwr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned BIT_BAT = 2;
  localparam int unsigned BIT_PF  = 1;
  localparam int unsigned BIT_POL = 0;

  typedef enum logic [STATE_W-1:0] {
    PS_S0 = 3'd0,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pstate_e;
endpackage

// File: rtl/rtc_pwr_sync.sv
module rtc_pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rtc_pwr_regs.sv
module rtc_pwr_regs
  import rtc_pwr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             batt_weak_i,
  input  logic             trickle_fail_i,
  input  logic             therm_trip_i,
  input  logic             rstctl_wr_i,
  output logic             bat_o,
  output logic             pf_o,
  output logic             pol_o
);
  logic bat_q, pf_q, pol_q;

  // battery flag: outside every reset domain
  always_ff @(posedge clk_i) begin
    if (batt_weak_i)                        bat_q <= 1'b1;
    else if (wr_en_i && !wr_data_i[BIT_BAT]) bat_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pf_q <= 1'b0;
    else if (trickle_fail_i)                 pf_q <= 1'b1;
    else if (wr_en_i && wr_data_i[BIT_PF])   pf_q <= 1'b0;
  end

  // set beats reset-control clear, which beats software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pol_q <= 1'b0;
    else if (therm_trip_i) pol_q <= 1'b1;
    else if (rstctl_wr_i)  pol_q <= 1'b0;
    else if (wr_en_i)      pol_q <= wr_data_i[BIT_POL];
  end

  assign bat_o = bat_q;
  assign pf_o  = pf_q;
  assign pol_o = pol_q;
endmodule

// File: rtl/rtc_pwr_resume.sv
module rtc_pwr_resume
  import rtc_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_good_i,
  input  logic               pol_i,
  input  logic [STATE_W-1:0] slp_state_i,
  output logic [STATE_W-1:0] res_state_o
);
  logic    pg_q;
  pstate_e res_q, res_d;

  always_comb begin
    if (!pol_i)                           res_d = PS_S0;
    else if (slp_state_i == STATE_W'(PS_S4)) res_d = PS_S4;
    else                                  res_d = PS_S5;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q  <= 1'b0;
      res_q <= PS_S0;
    end else begin
      pg_q <= pwr_good_i;
      if (pwr_good_i && !pg_q) res_q <= res_d;
    end
  end

  assign res_state_o = res_q;
endmodule

// File: rtl/rtc_pwr_status.sv
module rtc_pwr_status
  import rtc_pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rsm_rst_ni,
  input  logic               batt_weak_i,
  input  logic               trickle_fail_i,
  input  logic               therm_trip_i,
  input  logic               rstctl_wr_i,
  input  logic [STATE_W-1:0] slp_state_i,
  input  logic               pwr_good_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [STATE_W-1:0] res_state_o
);
  logic rsm_ok, bat, pf, pol;

  rtc_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rsm_rst_ni),
    .q_o   (rsm_ok)
  );

  rtc_pwr_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i && rsm_ok),
    .wr_data_i     (wr_data_i),
    .batt_weak_i   (batt_weak_i),
    .trickle_fail_i(trickle_fail_i),
    .therm_trip_i  (therm_trip_i),
    .rstctl_wr_i   (rstctl_wr_i),
    .bat_o         (bat),
    .pf_o          (pf),
    .pol_o         (pol)
  );

  rtc_pwr_resume u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .pol_i      (pol),
    .slp_state_i(slp_state_i),
    .res_state_o(res_state_o)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[BIT_BAT] = bat;
    rd_data_o[BIT_PF]  = pf;
    rd_data_o[BIT_POL] = pol;
  end
endmodule

// File: rtl/rtc_pwr_status_chk.sv
module rtc_pwr_status_chk
  import rtc_pwr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               batt_weak_i,
  input logic               trickle_fail_i,
  input logic               therm_trip_i,
  input logic               rstctl_wr_i,
  input logic [STATE_W-1:0] slp_state_i,
  input logic               pwr_good_i,
  input logic [REG_W-1:0]   rd_data_o,
  input logic [STATE_W-1:0] res_state_o
);
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:3] == '0); // R1
  AST_BAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_weak_i |=> rd_data_o[BIT_BAT]); // R2
  AST_PF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trickle_fail_i |=> rd_data_o[BIT_PF]); // R3
  AST_TRIP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_trip_i |=> rd_data_o[BIT_POL]); // R5
  AST_RSTCTL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstctl_wr_i && !therm_trip_i) |=> !rd_data_o[BIT_POL]); // R4
  AST_RES_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_good_i) && !rd_data_o[BIT_POL]) |=> res_state_o == STATE_W'(PS_S0)); // R6
  AST_RES_HIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_good_i) && rd_data_o[BIT_POL] && slp_state_i == STATE_W'(PS_S4))
    |=> res_state_o == STATE_W'(PS_S4)); // R6
  AST_RES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_good_i) && rd_data_o[BIT_POL] && slp_state_i != STATE_W'(PS_S4))
    |=> res_state_o == STATE_W'(PS_S5)); // R6
endmodule

bind rtc_pwr_status rtc_pwr_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .batt_weak_i   (batt_weak_i),
  .trickle_fail_i(trickle_fail_i),
  .therm_trip_i  (therm_trip_i),
  .rstctl_wr_i   (rstctl_wr_i),
  .slp_state_i   (slp_state_i),
  .pwr_good_i    (pwr_good_i),
  .rd_data_o     (rd_data_o),
  .res_state_o   (res_state_o)
);

// File: tb/sim_rtc_pwr_status.sv
`timescale 1ns/1ps
module sim_rtc_pwr_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rsm_rst_n = 1'b1;
  logic       batt_weak = 1'b1;
  logic       trickle_fail = 1'b0;
  logic       therm_trip = 1'b0;
  logic       rstctl_wr = 1'b0;
  logic [2:0] slp_state = 3'd0;
  logic       pwr_good = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] res_state;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_pwr_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .rsm_rst_ni(rsm_rst_n),
    .batt_weak_i(batt_weak), .trickle_fail_i(trickle_fail),
    .therm_trip_i(therm_trip), .rstctl_wr_i(rstctl_wr),
    .slp_state_i(slp_state), .pwr_good_i(pwr_good),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .res_state_o(res_state)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rst_pulse();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
  endtask

  task automatic t_reset();
    rst_pulse();
    batt_weak = 1'b0;
    chk("R1 reset read", rd_data, 8'h04);
    chk("R6 reset state", {5'd0, res_state}, 8'h00);
  endtask

  task automatic t_batt();
    wr(8'h04); chk("R2 write 1 keeps", rd_data, 8'h04);
    wr(8'h00); chk("R2 write 0 clears", rd_data, 8'h00);
    batt_weak = 1'b1; cyc(1); batt_weak = 1'b0;
    chk("R2 set", rd_data, 8'h04);
    rst_pulse(); chk("R2 survives reset", rd_data, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_pf();
    trickle_fail = 1'b1; cyc(1); trickle_fail = 1'b0;
    chk("R3 set", rd_data, 8'h02);
    wr(8'h00); chk("R3 write 0 keeps", rd_data, 8'h02);
    wr(8'h02); chk("R3 write 1 clears", rd_data, 8'h00);
    trickle_fail = 1'b1; cyc(1); trickle_fail = 1'b0;
    rst_pulse(); chk("R3 reset clears", rd_data, 8'h00);
  endtask

  task automatic t_pol();
    wr(8'h01); chk("R4 write 1", rd_data, 8'h01);
    wr(8'h00); chk("R4 write 0", rd_data, 8'h00);
    wr(8'h01); rstctl_wr = 1'b1; cyc(1); rstctl_wr = 1'b0;
    chk("R4 rstctl clears", rd_data, 8'h00);
    wr(8'h01); rst_pulse(); chk("R4 reset clears", rd_data, 8'h00);
    therm_trip = 1'b1; cyc(1); therm_trip = 1'b0;
    chk("R4 trip sets", rd_data, 8'h01);
    wr(8'hF8); chk("R1 unused bits zero", rd_data, 8'h00);
  endtask

  task automatic t_prio();
    batt_weak = 1'b1; wr(8'h00); batt_weak = 1'b0;
    chk("R5 batt set wins", rd_data, 8'h04);
    trickle_fail = 1'b1; wr(8'h06); trickle_fail = 1'b0;
    chk("R5 pf set wins", rd_data, 8'h06);
    therm_trip = 1'b1; rstctl_wr = 1'b1; wr(8'h06);
    therm_trip = 1'b0; rstctl_wr = 1'b0;
    chk("R5 trip wins", rd_data, 8'h05);
    wr(8'h02); chk("R5 cleanup", rd_data, 8'h00);
  endtask

  task automatic t_resume();
    pwr_good = 1'b1; cyc(1);
    chk("R6 policy 0 boots", {5'd0, res_state}, 8'h00);
    pwr_good = 1'b0; wr(8'h01); slp_state = 3'd4;
    pwr_good = 1'b1; cyc(1);
    chk("R6 keeps S4", {5'd0, res_state}, 8'h04);
    slp_state = 3'd5; cyc(2);
    chk("R6 holds while high", {5'd0, res_state}, 8'h04);
    pwr_good = 1'b0; slp_state = 3'd3; cyc(1);
    pwr_good = 1'b1; cyc(1);
    chk("R6 soft off", {5'd0, res_state}, 8'h05);
    pwr_good = 1'b0; cyc(1);
  endtask

  task automatic t_rsm();
    trickle_fail = 1'b1; cyc(1); trickle_fail = 1'b0;
    rsm_rst_n = 1'b0; cyc(3);
    wr(8'h02);
    chk("R7 write ignored, bits kept", rd_data, 8'h03);
    rsm_rst_n = 1'b1; cyc(1);
    wr(8'h02);
    chk("R7 sync latency", rd_data, 8'h03);
    cyc(1);
    wr(8'h02);
    chk("R7 write accepted", rd_data, 8'h00);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_batt();
    t_pf();
    t_pol();
    t_prio();
    t_resume();
    t_rsm();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule